// File: doc/BRIEF.md
# Host Controller Event SMI Register

This block is a 32-bit control/status register that watches a set of live host-controller state bits and latches a sticky flag whenever one of them changes. The monitored state is one ownership bit per root port, the power-state write strobe, the asynchronous and periodic schedule enables, the configure flag, the halted indication and the controller reset bit. Most flags are set on a change in either direction. The halted and reset flags are set only on a rising edge.

Each flag has a matching enable bit. When any flag and its enable are both 1, the block drives a registered system-management interrupt request. The request stays high until every enabled flag has been cleared. Software reads the register through a simple address/data port and clears flags by writing 1 to them. Only the suspend-well reset clears the register, so its contents survive warm and core resets.

Top module: `smi_evt_reg`

## Requirements
- R1: After the suspend-well reset, the register reads 00000000h at its offset (70h) and `smiReq` is 0.
- R2: Status bit 22+i is set in the cycle after port i's ownership bit changes, whether it rises or falls.
- R3: Status bit 20 (async schedule enable), bit 19 (periodic schedule enable) and bit 18 (configure flag) are each set in the cycle after their input changes in either direction.
- R4: Status bit 17 is set after `hcHalted` rises while `runStop` is 0. It is not set when `runStop` is 1 or when `hcHalted` falls. Status bit 16 is set only after `hcReset` rises, never on its fall.
- R5: Status bit 21 is set in the cycle after a cycle in which `pmcsrWrite` is 1.
- R6: A status bit is cleared by a write of 1 at offset 70h in an enabled byte lane (`regBe[k]` covers bits 8k+7:8k). Writing 0, or writing with the lane disabled, leaves the bit unchanged. If a set event and a clearing write hit the same bit in the same cycle, the bit ends up 1.
- R7: The enable bits are read/write, one byte lane at a time. Bit 0 enables reset, bit 1 halted, bit 2 configure, bit 3 periodic, bit 4 async, bit 5 power-state, and bit 6+i port i. Enables for ports that are not built read 0.
- R8: Reserved bits always read 0: bits 31 down to 22+NUM_PORTS, bits 15:14, and bits 13 down to 6+NUM_PORTS.
- R9: `smiReq` is 1 in the cycle after a cycle in which some status bit 16+k and enable bit k are both 1. It is 0 in the cycle after a cycle with no such pair.
- R10: A write to any other offset, or a cycle with `regWe` low, changes no register bit. `regRdata` is 0 whenever `regAddr` is not 70h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| suspRstN | input | 1 | Suspend-well reset, active low, asynchronous |
| regAddr | input | ADDR_W | Register address |
| regWe | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regBe | input | 4 | Byte-lane enables for writes |
| regRdata | output | 32 | Read data (combinational, 0 when the address does not match) |
| portOwner | input | NUM_PORTS | Live per-port ownership bits |
| asyncSchedEn | input | 1 | Live asynchronous schedule enable |
| periodicSchedEn | input | 1 | Live periodic schedule enable |
| cfgFlag | input | 1 | Live configure flag |
| hcHalted | input | 1 | Live halted indication |
| runStop | input | 1 | Live run/stop bit, qualifies the halted edge |
| hcReset | input | 1 | Live controller reset bit |
| pmcsrWrite | input | 1 | One-cycle strobe: the power-state bits were written |
| smiReq | output | 1 | Registered system-management interrupt request |

## Verification
A stale change tracker or a wrong set/clear priority shows up in the very next read of the register at 70h: a flag is missing or extra in the cycle after the input toggled. A wrong enable or status value reaches `smiReq` one cycle later, as a request that appears or drops in the wrong cycle. A lane-masking or decode fault shows up as a flag or enable that changes when a write should have had no effect. Every cycle therefore compares each field of the read value and the request line against a bench model, so a fault is seen within one or two cycles of its cause.

// File: rtl/smi_evt_pkg.sv
package smi_evt_pkg;

  localparam int REG_W      = 32;
  localparam int LANES      = REG_W / 8;
  localparam int STAT_LSB   = 16;
  localparam int FIXED_EVTS = 6;

  // Fixed event positions, counted from STAT_LSB (status) or 0 (enable)
  localparam int EV_RESET    = 0;
  localparam int EV_HALT     = 1;
  localparam int EV_CFG      = 2;
  localparam int EV_PERIODIC = 3;
  localparam int EV_ASYNC    = 4;
  localparam int EV_PWR      = 5;

  typedef enum logic {
    TRK_ANY  = 1'b0,
    TRK_RISE = 1'b1
  } trkMode_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic [REG_W-1:0] setMask;
    logic [REG_W-1:0] clrMask;
    logic [REG_W-1:0] enWrMask;
    logic [REG_W-1:0] enWrData;
  } ctlStrobes_t;

  function automatic logic [REG_W-1:0] laneMask(input logic [LANES-1:0] be);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) begin
      m[8*i +: 8] = {8{be[i]}};
    end
    return m;
  endfunction

endpackage

// File: rtl/smi_evt_tracker.sv
module smi_evt_tracker
  import smi_evt_pkg::*;
#(
  parameter trkMode_e MODE = TRK_ANY
) (
  input  logic clk,
  input  logic sigIn,
  input  logic qualIn,
  output logic evt
);

  // Follows the input in every cycle, including during reset, so that
  // no false change is seen when reset is released.
  logic prevQ;

  always_ff @(posedge clk) begin
    prevQ <= sigIn;
  end

  generate
    if (MODE == TRK_RISE) begin : g_rise
      assign evt = sigIn & ~prevQ & qualIn;
    end else begin : g_any
      assign evt = (sigIn ^ prevQ) & qualIn;
    end
  endgenerate

endmodule

// File: rtl/smi_evt_ctrl.sv
module smi_evt_ctrl
  import smi_evt_pkg::*;
#(
  parameter int                NUM_PORTS  = 6,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h70
) (
  input  logic                 clk,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWe,
  input  logic [REG_W-1:0]     regWdata,
  input  logic [LANES-1:0]     regBe,
  input  logic [NUM_PORTS-1:0] portOwner,
  input  logic                 asyncSchedEn,
  input  logic                 periodicSchedEn,
  input  logic                 cfgFlag,
  input  logic                 hcHalted,
  input  logic                 runStop,
  input  logic                 hcReset,
  input  logic                 pmcsrWrite,
  output logic                 regSel,
  output ctlStrobes_t          strobes
);

  localparam int EVT_N = FIXED_EVTS + NUM_PORTS;
  localparam logic [REG_W-1:0] EN_MASK   = REG_W'((64'd1 << EVT_N) - 64'd1);
  localparam logic [REG_W-1:0] STAT_MASK = EN_MASK << STAT_LSB;

  logic [EVT_N-1:0] evtVec;
  logic             wrHit;
  logic [REG_W-1:0] wrLanes;

  // Fixed change trackers
  smi_evt_tracker #(.MODE(TRK_RISE)) u_trkReset (
    .clk(clk), .sigIn(hcReset), .qualIn(1'b1), .evt(evtVec[EV_RESET])
  );
  smi_evt_tracker #(.MODE(TRK_RISE)) u_trkHalt (
    .clk(clk), .sigIn(hcHalted), .qualIn(~runStop), .evt(evtVec[EV_HALT])
  );
  smi_evt_tracker #(.MODE(TRK_ANY)) u_trkCfg (
    .clk(clk), .sigIn(cfgFlag), .qualIn(1'b1), .evt(evtVec[EV_CFG])
  );
  smi_evt_tracker #(.MODE(TRK_ANY)) u_trkPer (
    .clk(clk), .sigIn(periodicSchedEn), .qualIn(1'b1), .evt(evtVec[EV_PERIODIC])
  );
  smi_evt_tracker #(.MODE(TRK_ANY)) u_trkAsync (
    .clk(clk), .sigIn(asyncSchedEn), .qualIn(1'b1), .evt(evtVec[EV_ASYNC])
  );

  // The power-state write is already a strobe
  assign evtVec[EV_PWR] = pmcsrWrite;

  // One tracker per built port
  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      smi_evt_tracker #(.MODE(TRK_ANY)) u_trkOwn (
        .clk(clk), .sigIn(portOwner[p]), .qualIn(1'b1),
        .evt(evtVec[FIXED_EVTS + p])
      );
    end
  endgenerate

  // Register decode
  assign regSel  = (regAddr == REG_OFFSET);
  assign wrHit   = regWe && regSel;
  assign wrLanes = laneMask(regBe);

  always_comb begin
    strobes.setMask  = REG_W'(evtVec) << STAT_LSB;
    strobes.clrMask  = wrHit ? (regWdata & wrLanes & STAT_MASK) : '0;
    strobes.enWrMask = wrHit ? (wrLanes & EN_MASK) : '0;
    strobes.enWrData = regWdata;
  end

endmodule

// File: rtl/smi_evt_dp.sv
module smi_evt_dp
  import smi_evt_pkg::*;
#(
  parameter int NUM_PORTS = 6
) (
  input  logic             clk,
  input  logic             suspRstN,
  input  logic             regSel,
  input  ctlStrobes_t      strobes,
  output logic [REG_W-1:0] statusQ,
  output logic [REG_W-1:0] enableQ,
  output logic [REG_W-1:0] regRdata,
  output logic             smiReq
);

  localparam int EVT_N = FIXED_EVTS + NUM_PORTS;
  localparam logic [REG_W-1:0] EN_MASK   = REG_W'((64'd1 << EVT_N) - 64'd1);
  localparam logic [REG_W-1:0] STAT_MASK = EN_MASK << STAT_LSB;

  logic [REG_W-1:0] statusNext;
  logic [REG_W-1:0] enableNext;
  logic [EVT_N-1:0] pendVec;
  logic             smiQ;

  // Set is applied after clear: a same-cycle event survives
  assign statusNext = ((statusQ & ~strobes.clrMask) | strobes.setMask) & STAT_MASK;
  assign enableNext = (enableQ & ~strobes.enWrMask)
                    | (strobes.enWrData & strobes.enWrMask);

  assign pendVec = statusQ[STAT_LSB +: EVT_N] & enableQ[EVT_N-1:0];

  always_ff @(posedge clk or negedge suspRstN) begin
    if (!suspRstN) begin
      statusQ <= '0;
      enableQ <= '0;
      smiQ    <= 1'b0;
    end else begin
      statusQ <= statusNext;
      enableQ <= enableNext;
      smiQ    <= |pendVec;
    end
  end

  assign smiReq   = smiQ;
  assign regRdata = regSel ? (statusQ | enableQ) : '0;

endmodule

// File: rtl/smi_evt_reg.sv
module smi_evt_reg
  import smi_evt_pkg::*;
#(
  parameter int                NUM_PORTS  = 6,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h70
) (
  input  logic                 clk,
  input  logic                 suspRstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWe,
  input  logic [31:0]          regWdata,
  input  logic [3:0]           regBe,
  output logic [31:0]          regRdata,
  input  logic [NUM_PORTS-1:0] portOwner,
  input  logic                 asyncSchedEn,
  input  logic                 periodicSchedEn,
  input  logic                 cfgFlag,
  input  logic                 hcHalted,
  input  logic                 runStop,
  input  logic                 hcReset,
  input  logic                 pmcsrWrite,
  output logic                 smiReq
);

  ctlStrobes_t      strobes;
  logic             regSel;
  logic [REG_W-1:0] statusVec;
  logic [REG_W-1:0] enableVec;

  smi_evt_ctrl #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
  ) u_ctrl (
    .clk(clk),
    .regAddr(regAddr),
    .regWe(regWe),
    .regWdata(regWdata),
    .regBe(regBe),
    .portOwner(portOwner),
    .asyncSchedEn(asyncSchedEn),
    .periodicSchedEn(periodicSchedEn),
    .cfgFlag(cfgFlag),
    .hcHalted(hcHalted),
    .runStop(runStop),
    .hcReset(hcReset),
    .pmcsrWrite(pmcsrWrite),
    .regSel(regSel),
    .strobes(strobes)
  );

  smi_evt_dp #(.NUM_PORTS(NUM_PORTS)) u_dp (
    .clk(clk),
    .suspRstN(suspRstN),
    .regSel(regSel),
    .strobes(strobes),
    .statusQ(statusVec),
    .enableQ(enableVec),
    .regRdata(regRdata),
    .smiReq(smiReq)
  );

endmodule

// File: rtl/smi_evt_chk.sv
module smi_evt_chk #(
  parameter int                NUM_PORTS  = 6,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h70
) (
  input logic              clk,
  input logic              suspRstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [31:0]       regRdata,
  input logic              asyncSchedEn,
  input logic              hcReset,
  input logic              pmcsrWrite,
  input logic [31:0]       statusQ,
  input logic [31:0]       enableQ,
  input logic              smiReq
);

  localparam int EVT_N = 6 + NUM_PORTS;
  localparam logic [31:0] EN_MASK   = 32'((64'd1 << EVT_N) - 64'd1);
  localparam logic [31:0] RSVD_MASK = ~(EN_MASK | (EN_MASK << 16));

  logic anyPend;
  assign anyPend = |(statusQ[16 +: EVT_N] & enableQ[EVT_N-1:0]);

  // R5
  pwr_flag_set_chk: assert property (@(posedge clk) disable iff (!suspRstN)
    pmcsrWrite |=> statusQ[21]);

  // R4
  reset_rise_chk: assert property (@(posedge clk) disable iff (!suspRstN)
    $rose(hcReset) |=> statusQ[16]);

  // R3
  async_change_chk: assert property (@(posedge clk) disable iff (!suspRstN)
    !$stable(asyncSchedEn) |=> statusQ[20]);

  // R6
  sticky_status_chk: assert property (@(posedge clk) disable iff (!suspRstN)
    !regWe |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R9
  smi_raise_chk: assert property (@(posedge clk) disable iff (!suspRstN)
    anyPend |=> smiReq);

  // R9
  smi_drop_chk: assert property (@(posedge clk) disable iff (!suspRstN)
    !anyPend |=> !smiReq);

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!suspRstN)
    (regAddr == REG_OFFSET) |-> ((regRdata & RSVD_MASK) == 32'd0));

  // R10
  other_addr_chk: assert property (@(posedge clk) disable iff (!suspRstN)
    (regAddr != REG_OFFSET) |-> (regRdata == 32'd0));

endmodule

bind smi_evt_reg smi_evt_chk #(
  .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
) u_chk (
  .clk(clk),
  .suspRstN(suspRstN),
  .regAddr(regAddr),
  .regWe(regWe),
  .regRdata(regRdata),
  .asyncSchedEn(asyncSchedEn),
  .hcReset(hcReset),
  .pmcsrWrite(pmcsrWrite),
  .statusQ(statusVec),
  .enableQ(enableVec),
  .smiReq(smiReq)
);

// File: tb/smi_evt_reg_tb.sv
`timescale 1ns/1ps
module smi_evt_reg_tb;

  localparam int NP = 6;
  localparam logic [31:0] EM       = 32'((64'd1 << (6 + NP)) - 64'd1);
  localparam logic [31:0] SM       = EM << 16;
  localparam logic [31:0] PORT_SM  = 32'((64'd1 << NP) - 64'd1) << 22;
  localparam logic [31:0] FIX3_SM  = 32'h001C_0000;
  localparam logic [31:0] EDGE_SM  = 32'h0003_0000;
  localparam logic [31:0] PWR_SM   = 32'h0020_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [7:0]    nAddr = 8'h70;
  logic          nWe = 1'b0;
  logic [31:0]   nWd = '0;
  logic [3:0]    nBe = '0;
  logic [NP-1:0] nOwn = '0;
  logic nAsync = 0, nPer = 0, nCfg = 0, nHalt = 0, nRun = 0, nRst = 0, nPm = 0;
  logic [31:0]   rdata;
  logic          smi;

  smi_evt_reg #(.NUM_PORTS(NP), .ADDR_W(8), .REG_OFFSET(8'h70)) u_dut (
    .clk(clk), .suspRstN(rstN), .regAddr(nAddr), .regWe(nWe),
    .regWdata(nWd), .regBe(nBe), .regRdata(rdata), .portOwner(nOwn),
    .asyncSchedEn(nAsync), .periodicSchedEn(nPer), .cfgFlag(nCfg),
    .hcHalted(nHalt), .runStop(nRun), .hcReset(nRst),
    .pmcsrWrite(nPm), .smiReq(smi)
  );

  // Bench model
  logic [31:0]   mStat = '0, mEn = '0;
  logic          mSmi = 1'b0;
  logic [NP-1:0] pOwn = '0;
  logic pAsync = 0, pPer = 0, pCfg = 0, pHalt = 0, pRst = 0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] be);
    logic [31:0] m = '0;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [31:0] setVec();
    logic [31:0] s = '0;
    for (int i = 0; i < NP; i++) s[22+i] = nOwn[i] ^ pOwn[i];
    s[21] = nPm;
    s[20] = nAsync ^ pAsync;
    s[19] = nPer ^ pPer;
    s[18] = nCfg ^ pCfg;
    s[17] = nHalt & ~pHalt & ~nRun;
    s[16] = nRst & ~pRst;
    return s;
  endfunction

  task automatic checkAll();
    logic [31:0] exp;
    nAddr = 8'h70;
    nWe = 1'b0;
    #1;
    exp = mStat | mEn;
    chk("R2 port flags", rdata & PORT_SM, exp & PORT_SM);
    chk("R3 async/periodic/cfg flags", rdata & FIX3_SM, exp & FIX3_SM);
    chk("R4 halted/reset flags", rdata & EDGE_SM, exp & EDGE_SM);
    chk("R5 power flag", rdata & PWR_SM, exp & PWR_SM);
    chk("R7 enables", rdata & EM, exp & EM);
    chk("R8 reserved", rdata & ~(SM | EM), 32'd0);
    chk("R9 smi", 32'(smi), 32'(mSmi));
  endtask

  // Update the model with the stimulus now on the pins, then clock once
  task automatic step();
    logic [31:0] s, clr, enw, lm;
    logic hit, newSmi;
    s   = setVec();
    hit = nWe && (nAddr == 8'h70);
    lm  = lanes(nBe);
    clr = hit ? (nWd & lm & SM) : 32'd0;
    enw = hit ? (lm & EM) : 32'd0;
    newSmi = |((mStat >> 16) & mEn);
    mStat = ((mStat & ~clr) | s) & SM;
    mEn   = (mEn & ~enw) | (nWd & enw);
    mSmi  = newSmi;
    pOwn = nOwn; pAsync = nAsync; pPer = nPer; pCfg = nCfg;
    pHalt = nHalt; pRst = nRst;
    @(posedge clk);
    @(negedge clk);
    nPm = 1'b0;
    checkAll();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    nAddr = a; nWe = 1'b1; nWd = d; nBe = be;
    step();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    checkAll();
    // R1: reset state
    chk("R1 reset read", rdata, 32'd0);
    chk("R1 reset smi", 32'(smi), 32'd0);

    // R2: rise and fall of port 0 ownership
    nOwn = 6'b000001; step();
    chk("R2 rise", 32'(rdata[22]), 32'd1);
    wr(8'h70, 32'h0040_0000, 4'hF);
    chk("R6 w1c", 32'(rdata[22]), 32'd0);
    nOwn = '0; step();
    chk("R2 fall", 32'(rdata[22]), 32'd1);

    // R4: halted qualified by run/stop; reset rise only
    nRun = 1'b1; nHalt = 1'b1; step();
    chk("R4 halted with run set", 32'(rdata[17]), 32'd0);
    nHalt = 1'b0; step();
    nRun = 1'b0; nHalt = 1'b1; step();
    chk("R4 halted with run clear", 32'(rdata[17]), 32'd1);
    nRst = 1'b1; step();
    chk("R4 reset rise", 32'(rdata[16]), 32'd1);
    wr(8'h70, 32'hFFFF_0000, 4'hC);
    chk("R6 clear all", rdata >> 16, 32'd0);
    nRst = 1'b0; step();
    chk("R4 reset fall ignored", 32'(rdata[16]), 32'd0);

    // R5: power-state write strobe
    nPm = 1'b1; step();
    chk("R5 power flag", 32'(rdata[21]), 32'd1);

    // R6: set wins over same-cycle clear
    wr(8'h70, 32'hFFFF_0000, 4'hC);
    nCfg = ~nCfg;
    wr(8'h70, 32'h0004_0000, 4'hF);
    chk("R6 set beats clear", 32'(rdata[18]), 32'd1);
    wr(8'h70, 32'hFFFF_FFFF, 4'h0);
    chk("R6 lanes off", 32'(rdata[18]), 32'd1);
    wr(8'h70, 32'h0000_0000, 4'hF);
    chk("R6 write zero", 32'(rdata[18]), 32'd1);

    // R7: enables, unbuilt ports read 0
    wr(8'h70, 32'h0000_FFFF, 4'h3);
    chk("R7 enable field", rdata & 32'h0000_FFFF, 32'h0000_0FFF);

    // R10: other offset and idle cycles have no effect
    wr(8'h74, 32'h0000_0000, 4'hF);
    chk("R10 other offset write", rdata & 32'h0000_FFFF, 32'h0000_0FFF);
    nWd = 32'h0; nBe = 4'hF; step();
    chk("R10 regWe low", rdata & 32'h0000_FFFF, 32'h0000_0FFF);
    nAddr = 8'h74; #1;
    chk("R10 other offset read", rdata, 32'd0);

    // R9: request timing
    wr(8'h70, 32'hFFFF_0001, 4'hF);
    step();
    chk("R9 idle low", 32'(smi), 32'd0);
    nRst = 1'b1; step();
    chk("R9 flag seen, smi not yet", 32'(smi), 32'd0);
    step();
    chk("R9 smi high", 32'(smi), 32'd1);
    wr(8'h70, 32'h0001_0000, 4'hF);
    chk("R9 smi lingers one cycle", 32'(smi), 32'd1);
    step();
    chk("R9 smi low", 32'(smi), 32'd0);

    // Random phase
    for (int n = 0; n < 1500; n++) begin
      for (int i = 0; i < NP; i++) if ($urandom % 8 == 0) nOwn[i] = ~nOwn[i];
      if ($urandom % 8 == 0) nAsync = ~nAsync;
      if ($urandom % 8 == 0) nPer = ~nPer;
      if ($urandom % 8 == 0) nCfg = ~nCfg;
      if ($urandom % 6 == 0) nHalt = ~nHalt;
      if ($urandom % 4 == 0) nRun = ~nRun;
      if ($urandom % 8 == 0) nRst = ~nRst;
      nPm = ($urandom % 10 == 0);
      if ($urandom % 3 == 0) begin
        nWe = 1'b1;
        nWd = $urandom;
        nBe = 4'($urandom);
        if ($urandom % 4 == 0) begin
          nAddr = 8'($urandom);
          if (nAddr == 8'h70) nAddr = 8'h71;
        end
      end
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule